// File: doc/BRIEF.md
# Dual-Band Receiver Control Sequencer

This block drives the digital control pins of a two-band time-signal receiver front end. Two control lines pick between three conditions: powered down, the higher-frequency band, or the lower-frequency band. A third line either freezes the front end's gain control or lets it run. A host sends single-cycle commands to power off, power on, or choose a band. The sequencer turns each command into a safe sequence on the lines and raises a valid flag once received data can be trusted again.

The front end only performs its fast start when it leaves power-down after a long enough stay there. For that reason the sequencer never moves the lines straight from one band to the other. Every band change goes through a power-down interval of at least `PD_MS` millisecond ticks. After that comes a settle interval of `SETTLE_MS` ticks, and only then is data marked valid. A noise-window input, raised by whatever produces the disturbance (a motor drive pulse, for example), freezes gain control for as long as it is active and the front end is powered.

All timing counts pulses on `ms_tick`, so the two intervals are plain parameters.

The states are:
- OFF: idle and powered down.
- PD_HOLD: powered down while the minimum interval is counted.
- STARTING: powered on the selected band while the settle time is counted.
- RUN: powered, with data valid.

The transitions are:
- OFF→PD_HOLD on a power-on command.
- PD_HOLD→STARTING when the interval has elapsed.
- STARTING→RUN when the settle time has elapsed.
- STARTING/RUN→PD_HOLD on a command for a different band.
- PD_HOLD/STARTING/RUN→OFF on a power-off command.

Top module: `rx_band_seq`

## Requirements
- R1: After reset, and while reset is held, both control lines are high, the gain line is high and `data_valid` is low. The target band is 0 and the state is OFF.
- R2: The control lines encode the condition as follows. Powered-down is `pdn_a`=1, `pdn_b`=1. Band 0 (the higher frequency) is `pdn_a`=1, `pdn_b`=0. Band 1 (the lower frequency) is `pdn_a`=0, `pdn_b`=0. The combination `pdn_a`=0, `pdn_b`=1 never appears.
- R3: After a power-on command (`req_cmd`=2'b01) in OFF, the lines leave power-down only once `PD_MS` ticks have been counted since the most recent entry into power-down. Ticks counted in OFF before the command are included. The lines then go to the target band.
- R4: `data_valid` rises only after `SETTLE_MS` ticks have been counted while powered, and it is high only in RUN.
- R5: A band command (`req_cmd`=2'b11, band on `req_band`) for a band different from the current one, given in STARTING or RUN, drives both lines high on the next cycle and drops `data_valid`. The lines come up on the new band after `PD_MS` further ticks. They never move directly from one band encoding to the other.
- R6: A band command for the band already in use, given in STARTING or RUN, has no effect on the lines or on `data_valid`.
- R7: A power-off command (`req_cmd`=2'b10) in PD_HOLD, STARTING or RUN returns to OFF. The lines are high and `data_valid` is low on the next cycle.
- R8: While powered, a high `noise_win` drives `agc_run` low one cycle later, and `agc_run` returns high one cycle after `noise_win` falls. While powered down, `agc_run` stays high whatever `noise_win` does.
- R9: A band command in OFF or PD_HOLD changes the target band without powering up. A later power-up uses that band.
- R10: A power-on command in STARTING or RUN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| req_cmd | input | 2 | Command: 00 none, 01 power on, 10 power off, 11 band select |
| req_band | input | 1 | Band for a band-select command (0 higher, 1 lower frequency) |
| noise_win | input | 1 | Disturbance window active |
| pdn_a | output | 1 | Front-end control line A |
| pdn_b | output | 1 | Front-end control line B |
| agc_run | output | 1 | Gain-control line: 1 runs, 0 freezes |
| data_valid | output | 1 | Received data trustworthy (RUN only) |

## Verification
The hardest situation to reach is a power-up whose power-down interval is split across states. The count starts in OFF, continues through PD_HOLD, and is interrupted by a power-off and then resumed by a fresh power-on. Here a counter that clears too often, or not often enough, changes the cycle on which the lines come up. The stimulus table issues a band change during STARTING and lets a few ticks pass. It then commands OFF and ON again, and checks that the lines come up exactly once the combined tick count reaches the interval. A similar row delivers all the ticks in OFF, so that power-on leads straight to STARTING.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_PD_HOLD  = 2'd1,
        ST_STARTING = 2'd2,
        ST_RUN      = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_ON   = 2'b01,
        CMD_OFF  = 2'b10,
        CMD_BAND = 2'b11
    } seq_cmd_e;

endpackage

// File: rtl/rx_ms_timer.sv
module rx_ms_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q >= limit);

endmodule

// File: rtl/rx_line_enc.sv
module rx_line_enc
    import rx_seq_pkg::*;
#(
    parameter logic LOW_BAND_B = 1'b0
) (
    input  seq_state_e state,
    input  logic       band,
    output logic       line_a,
    output logic       line_b,
    output logic       powered
);
    always_comb begin
        powered = (state == ST_STARTING) || (state == ST_RUN);
        if (!powered) begin
            line_a = 1'b1;
            line_b = 1'b1;
        end else if (!band) begin
            line_a = 1'b1;
            line_b = 1'b0;
        end else begin
            line_a = 1'b0;
            line_b = LOW_BAND_B;
        end
    end

endmodule

// File: rtl/rx_agc_gate.sv
module rx_agc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic noise_win,
    input  logic powered,
    output logic agc_run
);
    logic noise_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            noise_q <= 1'b0;
        end else begin
            noise_q <= noise_win;
        end
    end

    assign agc_run = !(noise_q && powered);

endmodule

// File: rtl/rx_band_seq.sv
module rx_band_seq
    import rx_seq_pkg::*;
#(
    parameter int PD_MS     = 50,
    parameter int SETTLE_MS = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic [1:0] req_cmd,
    input  logic       req_band,
    input  logic       noise_win,
    output logic       pdn_a,
    output logic       pdn_b,
    output logic       agc_run,
    output logic       data_valid
);
    localparam int CNT_MAX = (PD_MS > SETTLE_MS) ? PD_MS : SETTLE_MS;
    localparam int CNT_W   = $clog2(CNT_MAX + 2);
    localparam logic [CNT_W-1:0] PD_LIM  = CNT_W'(PD_MS);
    localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETTLE_MS);

    seq_state_e       state_q, state_d;
    logic             band_q, band_d;
    logic             tmr_clr, tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    logic             powered;
    seq_cmd_e         cmd;

    assign cmd = seq_cmd_e'(req_cmd);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            band_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            band_q  <= band_d;
        end
    end

    always_comb begin
        state_d = state_q;
        band_d  = band_q;
        tmr_clr = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cmd == CMD_BAND) begin
                    band_d = req_band;
                end else if (cmd == CMD_ON) begin
                    state_d = ST_PD_HOLD;
                end
            end
            ST_PD_HOLD: begin
                if (cmd == CMD_OFF) begin
                    state_d = ST_OFF;
                end else begin
                    if (cmd == CMD_BAND) begin
                        band_d = req_band;
                    end
                    if (tmr_done) begin
                        state_d = ST_STARTING;
                        tmr_clr = 1'b1;
                    end
                end
            end
            ST_STARTING: begin
                if (cmd == CMD_OFF) begin
                    state_d = ST_OFF;
                    tmr_clr = 1'b1;
                end else if (cmd == CMD_BAND && req_band != band_q) begin
                    band_d  = req_band;
                    state_d = ST_PD_HOLD;
                    tmr_clr = 1'b1;
                end else if (tmr_done) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cmd == CMD_OFF) begin
                    state_d = ST_OFF;
                    tmr_clr = 1'b1;
                end else if (cmd == CMD_BAND && req_band != band_q) begin
                    band_d  = req_band;
                    state_d = ST_PD_HOLD;
                    tmr_clr = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        data_valid = (state_q == ST_RUN);
        tmr_limit  = (state_q == ST_STARTING) ? SET_LIM : PD_LIM;
    end

    rx_ms_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (ms_tick),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    rx_line_enc #(.LOW_BAND_B(1'b0)) u_enc (
        .state   (state_q),
        .band    (band_q),
        .line_a  (pdn_a),
        .line_b  (pdn_b),
        .powered (powered)
    );

    rx_agc_gate u_agc (
        .clk       (clk),
        .rst_n     (rst_n),
        .noise_win (noise_win),
        .powered   (powered),
        .agc_run   (agc_run)
    );

endmodule

// File: rtl/rx_band_seq_chk.sv
module rx_band_seq_chk #(
    parameter int PD_MS     = 50,
    parameter int SETTLE_MS = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic noise_win,
    input logic pdn_a,
    input logic pdn_b,
    input logic agc_run,
    input logic data_valid
);
    localparam int CW = $clog2(((PD_MS > SETTLE_MS) ? PD_MS : SETTLE_MS) + 2);

    logic          pwr;
    logic [CW-1:0] down_cnt, up_cnt;

    assign pwr = !(pdn_a && pdn_b);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_cnt <= '0;
            up_cnt   <= '0;
        end else begin
            if (pwr) down_cnt <= '0;
            else if (ms_tick && down_cnt != {CW{1'b1}}) down_cnt <= down_cnt + 1'b1;
            if (!pwr) up_cnt <= '0;
            else if (ms_tick && up_cnt != {CW{1'b1}}) up_cnt <= up_cnt + 1'b1;
        end
    end

    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_a || !pdn_b);

    p_pd_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && !$past(pwr)) |-> ($past(down_cnt) >= CW'(PD_MS)));

    p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> ($past(up_cnt) >= CW'(SETTLE_MS)));

    p_valid_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> pwr);

    p_no_direct_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && $past(pwr)) |-> $stable(pdn_a));

    p_freeze_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !agc_run |-> ($past(noise_win) && pwr));

    p_release_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |-> agc_run);

endmodule

bind rx_band_seq rx_band_seq_chk #(.PD_MS(PD_MS), .SETTLE_MS(SETTLE_MS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .noise_win  (noise_win),
    .pdn_a      (pdn_a),
    .pdn_b      (pdn_b),
    .agc_run    (agc_run),
    .data_valid (data_valid)
);

// File: tb/test_rx_band_seq.sv
module test_rx_band_seq;

    localparam int PD_MS     = 5;
    localparam int SETTLE_MS = 8;
    localparam int NROW      = 17;

    typedef struct packed {
        logic [1:0] cmd;
        logic       band;
        logic [7:0] ticks;
        logic [2:0] exp;   // {pdn_a, pdn_b, data_valid}
        logic [7:0] req;
    } row_t;

    // cmd: 00 none, 01 on, 10 off, 11 band
    localparam row_t ROWS [NROW] = '{
        '{2'b01, 1'b0, 8'd4, 3'b110, 8'd3},   // R3 on, interval not yet met
        '{2'b00, 1'b0, 8'd1, 3'b100, 8'd2},   // R2 R3 band 0 powered
        '{2'b00, 1'b0, 8'd7, 3'b100, 8'd4},   // R4 settle not done
        '{2'b00, 1'b0, 8'd1, 3'b101, 8'd4},   // R4 RUN
        '{2'b11, 1'b0, 8'd0, 3'b101, 8'd6},   // R6 same band in RUN
        '{2'b11, 1'b1, 8'd0, 3'b110, 8'd5},   // R5 band change -> power-down
        '{2'b00, 1'b0, 8'd4, 3'b110, 8'd5},   // R5 still held
        '{2'b00, 1'b0, 8'd1, 3'b000, 8'd2},   // R2 R5 band 1 powered
        '{2'b00, 1'b0, 8'd8, 3'b001, 8'd4},   // R4 RUN on band 1
        '{2'b01, 1'b0, 8'd0, 3'b001, 8'd10},  // R10 on ignored
        '{2'b10, 1'b0, 8'd0, 3'b110, 8'd7},   // R7 off from RUN
        '{2'b11, 1'b0, 8'd5, 3'b110, 8'd9},   // R9 band in OFF stays down
        '{2'b01, 1'b0, 8'd0, 3'b100, 8'd9},   // R9 R3 ticks in OFF count
        '{2'b11, 1'b1, 8'd3, 3'b110, 8'd5},   // R5 change during STARTING
        '{2'b10, 1'b0, 8'd0, 3'b110, 8'd7},   // R7 off from PD_HOLD
        '{2'b01, 1'b0, 8'd2, 3'b000, 8'd3},   // R3 interval resumes across OFF
        '{2'b11, 1'b1, 8'd0, 3'b000, 8'd6}    // R6 same band in STARTING
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic [1:0] req_cmd = 2'b00;
    logic       req_band = 1'b0;
    logic       noise_win = 1'b0;
    logic       pdn_a, pdn_b, agc_run, data_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_band_seq #(.PD_MS(PD_MS), .SETTLE_MS(SETTLE_MS)) i_rx_band_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (ms_tick),
        .req_cmd    (req_cmd),
        .req_band   (req_band),
        .noise_win  (noise_win),
        .pdn_a      (pdn_a),
        .pdn_b      (pdn_b),
        .agc_run    (agc_run),
        .data_valid (data_valid)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic send(input logic [1:0] c, input logic b);
        req_cmd  = c;
        req_band = b;
        @(negedge clk);
        req_cmd  = 2'b00;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state: {a, b, agc, valid}
        check("R1 during reset", {pdn_a, pdn_b, agc_run, data_valid}, 4'b1110);
        rst_n = 1'b1;
        idle(2);
        check("R1 after reset", {pdn_a, pdn_b, agc_run, data_valid}, 4'b1110);

        for (int r = 0; r < NROW; r++) begin
            send(ROWS[r].cmd, ROWS[r].band);
            pulse_tick(int'(ROWS[r].ticks));
            idle(2);
            check($sformatf("R%0d row %0d", ROWS[r].req, r),
                  {1'b0, pdn_a, pdn_b, data_valid}, {1'b0, ROWS[r].exp});
        end

        // R8 freeze while powered (STARTING on band 1)
        noise_win = 1'b1;
        @(negedge clk);
        check("R8 freeze", {3'b0, agc_run}, 4'b0000);
        noise_win = 1'b0;
        @(negedge clk);
        check("R8 release", {3'b0, agc_run}, 4'b0001);

        // R8 no freeze while powered down, R7 off from STARTING
        send(2'b10, 1'b0);
        noise_win = 1'b1;
        idle(2);
        check("R8 R7 held high when down", {pdn_a, pdn_b, agc_run, data_valid}, 4'b1110);
        noise_win = 1'b0;

        // R1 reset in mid-operation
        pulse_tick(5);
        send(2'b01, 1'b0);
        idle(2);
        check("R2 powered before reset", {1'b0, pdn_a, pdn_b, data_valid}, 4'b0000);
        rst_n = 1'b0;
        idle(2);
        check("R1 mid-run reset", {pdn_a, pdn_b, agc_run, data_valid}, 4'b1110);
        rst_n = 1'b1;
        idle(2);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule